// File: doc/BRIEF.md
# Flash Memory Command Controller

This block sits in front of a small on-chip flash array and turns register writes into array operations. Software loads an address register and a 16-bit data register, then writes an 8-bit command code. The controller checks the code, refuses anything reserved, locked or aimed at guarded pages, and otherwise starts the operation. Each operation is timed by a cycle counter. When the counter expires, the array is updated and the command register switches to its completion value.

The operations are single read, single write, erase-then-write, verify, page erase, mass erase, a 24-bit LFSR signature pass over the whole array, and a one-time page protect. A ping command does nothing except raise the interrupt. The top pages of the array form a kernel region that no command may write or erase. The array comes out of reset with the user pages erased (0xFFFF) and with a fixed pattern in the kernel pages.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0x07, the status bits, `irq`, `prot_mask`, `signature` and `read_word` are all zero. User words read 0xFFFF and kernel word i reads 0xA000 | i.
- R2: A bus write selects a register through `bus_sel`: 0 is the address, 1 is the data, 2 is the command (low 8 bits) and 3 is the key. While a timed command runs, `cmd_rd` shows its code. From the first cycle after completion, and after every command that returns at once, `cmd_rd` reads 0x07.
- R3: `status[2]` (busy) rises in the cycle after a timed command is accepted and stays high for exactly the cycle count set for that operation. Every bus write made while busy is ignored.
- R4: Code 0x02 stores the data register at the addressed word. Code 0x01 copies the addressed word to `read_word`.
- R5: Code 0x03 sets every word of the addressed page to 0xFFFF and then writes the data register to the addressed word.
- R6: Code 0x04 compares the addressed word with the data register. It sets `status[0]` on a match and `status[1]` on a mismatch, and never sets both.
- R7: Code 0x05 sets every word of the addressed page to 0xFFFF.
- R8: Code 0x06 runs only if the last accepted bus write was a key write of the unlock key 0xC3A5. It then erases all user pages, leaves the kernel pages unchanged and clears the protection. Without the unlock it sets `status[4]` and leaves the array untouched.
- R9: Code 0x0B walks words 0 to WORDS-1, starting from 0xFFFFFF. Each word updates the value to (s<<1, truncated to 24 bits) XOR (s[23] ? 0x80001B : 0) XOR word. The final value is placed in `signature`.
- R10: Code 0x0C loads `prot_mask` from the low PAGES bits of the data register. A second protect sets `status[4]` until a key write of 0x5A3C (or a mass erase) clears both the mask and the once-only lock.
- R11: A write, erase-then-write or page erase that targets a kernel page or a page whose `prot_mask` bit is set is refused. The refusal sets `status[3]`, does not go busy and changes no word.
- R12: Codes other than 0x00-0x06, 0x0B, 0x0C and 0x0F set `status[4]` and return at once. Ping (0x0F) returns at once without an error. Each accepted command clears status bits 0, 1, 3 and 4 first.
- R13: `irq` pulses for one cycle at the end of every command except null (0x00). This includes commands that are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 command, 3 key |
| bus_wdata | input | 16 | Write data |
| cmd_rd | output | 8 | Command register read value |
| status | output | 5 | {cmd error, access error, busy, verify fail, verify pass} |
| read_word | output | 16 | Result of the last read command |
| signature | output | 24 | Result of the last signature command |
| prot_mask | output | PAGES | One protect bit per page |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with 64 words in 8-word pages and one kernel page. Operation lengths are 2, 6, 20, 3, 10, 24, 70 and 4 cycles, so every busy window can be counted exactly. With only 8 pages, random addresses hit the kernel page and the protected pages often, so refusals occur mixed in with normal accesses. A 64-word signature pass finishes within its 70-cycle window, and the bench can read back the whole array after each group of operations.

// File: rtl/flc_pkg.sv
package flc_pkg;

  typedef enum logic [3:0] {
    OP_NULL   = 4'h0,
    OP_READ   = 4'h1,
    OP_WRITE  = 4'h2,
    OP_ERWR   = 4'h3,
    OP_VERIFY = 4'h4,
    OP_PERASE = 4'h5,
    OP_MASS   = 4'h6,
    OP_SIG    = 4'hB,
    OP_PROT   = 4'hC,
    OP_PING   = 4'hF
  } flc_op_e;

  localparam logic [7:0]  CMD_DONE   = 8'h07;
  localparam logic [15:0] ERASED     = 16'hFFFF;
  localparam logic [23:0] SIG_SEED   = 24'hFFFFFF;
  localparam logic [23:0] SIG_POLY   = 24'h80001B;

  localparam int ST_PASS   = 0;
  localparam int ST_FAIL   = 1;
  localparam int ST_BUSY   = 2;
  localparam int ST_ACCERR = 3;
  localparam int ST_CMDERR = 4;
  localparam int ST_W      = 5;

  // one LFSR step folding in a data word
  function automatic logic [23:0] sig_step(input logic [23:0] s, input logic [15:0] w);
    return {s[22:0], 1'b0} ^ (s[23] ? SIG_POLY : 24'h0) ^ {8'h00, w};
  endfunction

  // reset content of word i; kernel words carry a fixed pattern
  function automatic logic [15:0] init_word(input int i, input int user_words);
    logic [15:0] iw;
    iw = 16'(i);
    return (i >= user_words) ? (16'hA000 | iw) : ERASED;
  endfunction

  function automatic logic code_known(input logic [7:0] c);
    logic ok;
    case (c)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
      8'h0B, 8'h0C, 8'h0F: ok = 1'b1;
      default:             ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/flc_timer.sv
module flc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/flc_array.sv
module flc_array import flc_pkg::*; #(
  parameter int WORDS        = 64,
  parameter int PAGE_WORDS   = 8,
  parameter int KERNEL_PAGES = 1,
  localparam int AW          = $clog2(WORDS),
  localparam int PAGES       = WORDS / PAGE_WORDS,
  localparam int PGW         = $clog2(PAGES),
  localparam int USER_PAGES  = PAGES - KERNEL_PAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [15:0]    wr_data,
  input  logic           pg_erase_en,
  input  logic [PGW-1:0] pg_sel,
  input  logic           mass_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [15:0]    rd_data,
  input  logic [AW-1:0]  scan_addr,
  output logic [15:0]    scan_data
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i, USER_PAGES * PAGE_WORDS);
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (mass_en && (i / PAGE_WORDS) < USER_PAGES) mem[i] <= ERASED;
        if (pg_erase_en && PGW'(i / PAGE_WORDS) == pg_sel) mem[i] <= ERASED;
        if (wr_en && AW'(i) == wr_addr) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data   = mem[rd_addr];
  assign scan_data = mem[scan_addr];
endmodule

// File: rtl/flc_sig.sv
module flc_sig import flc_pkg::*; #(
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   scan_data,
  output logic [AW-1:0] scan_addr,
  output logic [23:0]   acc
);
  logic [AW-1:0] idx;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      active <= 1'b0;
      acc    <= '0;
    end else if (start) begin
      idx    <= '0;
      active <= 1'b1;
      acc    <= SIG_SEED;
    end else if (active) begin
      acc <= sig_step(acc, scan_data);
      idx <= idx + 1'b1;
      if (idx == AW'(WORDS - 1)) active <= 1'b0;
    end
  end

  assign scan_addr = idx;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import flc_pkg::*; #(
  parameter int          WORDS        = 64,
  parameter int          PAGE_WORDS   = 8,
  parameter int          KERNEL_PAGES = 1,
  parameter int          T_READ       = 2,
  parameter int          T_WRITE      = 6,
  parameter int          T_ERWR       = 20,
  parameter int          T_VERIFY     = 3,
  parameter int          T_PERASE     = 10,
  parameter int          T_MASS       = 24,
  parameter int          T_SIG        = 70,
  parameter int          T_PROT       = 4,
  parameter logic [15:0] UNLOCK_KEY   = 16'hC3A5,
  parameter logic [15:0] CLEAR_KEY    = 16'h5A3C,
  localparam int         PAGES        = WORDS / PAGE_WORDS,
  localparam int         AW           = $clog2(WORDS),
  localparam int         PB           = $clog2(PAGE_WORDS),
  localparam int         PGW          = $clog2(PAGES),
  localparam int         USER_PAGES   = PAGES - KERNEL_PAGES,
  localparam int         CW           = $clog2(T_READ + T_WRITE + T_ERWR + T_VERIFY
                                               + T_PERASE + T_MASS + T_SIG + T_PROT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_sel,
  input  logic [15:0]      bus_wdata,
  output logic [7:0]       cmd_rd,
  output logic [ST_W-1:0]  status,
  output logic [15:0]      read_word,
  output logic [23:0]      signature,
  output logic [PAGES-1:0] prot_mask,
  output logic             irq
);
  function automatic logic [CW-1:0] op_len(input flc_op_e op);
    int n;
    case (op)
      OP_READ:   n = T_READ;
      OP_WRITE:  n = T_WRITE;
      OP_ERWR:   n = T_ERWR;
      OP_VERIFY: n = T_VERIFY;
      OP_PERASE: n = T_PERASE;
      OP_MASS:   n = T_MASS;
      OP_SIG:    n = T_SIG;
      OP_PROT:   n = T_PROT;
      default:   n = 0;
    endcase
    return CW'(n);
  endfunction

  // registers
  logic [AW-1:0]    addr_q;
  logic [15:0]      data_q;
  logic [7:0]       cmd_q;
  logic             st_pass, st_fail, st_acc, st_cmd;
  logic [15:0]      read_q;
  logic [23:0]      sig_q;
  logic [PAGES-1:0] prot_q;
  logic             prot_done;
  logic             armed;
  logic             irq_q;
  flc_op_e          op_q;

  // named internal events
  logic             busy, done;
  logic             wr_ok, cmd_wr, key_wr;
  logic [7:0]       code;
  logic             known;
  flc_op_e          op_c;
  logic [PGW-1:0]   tgt_page;
  logic             is_kernel, modifies, timed;
  logic             refuse_acc, refuse_cmd, start, imm;
  logic             arr_wr_en, pg_erase_en, mass_en;
  logic             kernel_touch, mass_start, sig_start;
  logic [15:0]      rd_data, scan_data;
  logic [AW-1:0]    scan_addr;
  logic [23:0]      sig_acc;

  assign wr_ok     = bus_wr && !busy;
  assign cmd_wr    = wr_ok && (bus_sel == 2'd2);
  assign key_wr    = wr_ok && (bus_sel == 2'd3);
  assign code      = bus_wdata[7:0];
  assign known     = code_known(code);
  assign op_c      = flc_op_e'(code[3:0]);
  assign tgt_page  = addr_q[AW-1:PB];
  assign is_kernel = (tgt_page >= PGW'(USER_PAGES));
  assign modifies  = (op_c == OP_WRITE) || (op_c == OP_ERWR) || (op_c == OP_PERASE);
  assign timed     = (op_len(op_c) != '0);

  assign refuse_cmd = cmd_wr && (!known || (op_c == OP_MASS && !armed)
                                        || (op_c == OP_PROT && prot_done));
  assign refuse_acc = cmd_wr && known && !refuse_cmd && modifies
                      && (is_kernel || prot_q[tgt_page]);
  assign start      = cmd_wr && known && !refuse_cmd && !refuse_acc && timed;
  assign imm        = cmd_wr && !start;
  assign mass_start = start && (op_c == OP_MASS);
  assign sig_start  = start && (op_c == OP_SIG);

  assign arr_wr_en    = done && (op_q == OP_WRITE || op_q == OP_ERWR);
  assign pg_erase_en  = done && (op_q == OP_ERWR || op_q == OP_PERASE);
  assign mass_en      = done && (op_q == OP_MASS);
  assign kernel_touch = (arr_wr_en || pg_erase_en) && is_kernel;

  flc_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .len(op_len(op_c)),
    .busy(busy), .done(done)
  );

  flc_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .KERNEL_PAGES(KERNEL_PAGES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(arr_wr_en), .wr_addr(addr_q), .wr_data(data_q),
    .pg_erase_en(pg_erase_en), .pg_sel(tgt_page), .mass_en(mass_en),
    .rd_addr(addr_q), .rd_data(rd_data),
    .scan_addr(scan_addr), .scan_data(scan_data)
  );

  flc_sig #(.WORDS(WORDS)) u_sig (
    .clk(clk), .rst_n(rst_n), .start(sig_start),
    .scan_data(scan_data), .scan_addr(scan_addr), .acc(sig_acc)
  );

  // bus registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      if (bus_sel == 2'd0) addr_q <= bus_wdata[AW-1:0];
      if (bus_sel == 2'd1) data_q <= bus_wdata;
    end
  end

  // command register, operation latch, interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_DONE;
      op_q  <= OP_NULL;
      irq_q <= 1'b0;
    end else begin
      irq_q <= done || (imm && code != 8'h00);
      if (cmd_wr) begin
        cmd_q <= start ? code : CMD_DONE;
        if (start) op_q <= op_c;
      end else if (done) begin
        cmd_q <= CMD_DONE;
      end
    end
  end

  // status, results, protection, unlock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pass   <= 1'b0;
      st_fail   <= 1'b0;
      st_acc    <= 1'b0;
      st_cmd    <= 1'b0;
      read_q    <= '0;
      sig_q     <= '0;
      prot_q    <= '0;
      prot_done <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (wr_ok) armed <= key_wr && (bus_wdata == UNLOCK_KEY);
      if (key_wr && bus_wdata == CLEAR_KEY) begin
        prot_q    <= '0;
        prot_done <= 1'b0;
      end
      if (cmd_wr) begin
        st_pass <= 1'b0;
        st_fail <= 1'b0;
        st_acc  <= refuse_acc;
        st_cmd  <= refuse_cmd;
      end
      if (done) begin
        case (op_q)
          OP_READ:   read_q <= rd_data;
          OP_VERIFY: begin
            st_pass <= (rd_data == data_q);
            st_fail <= (rd_data != data_q);
          end
          OP_SIG:    sig_q <= sig_acc;
          OP_PROT:   begin
            prot_q    <= data_q[PAGES-1:0];
            prot_done <= 1'b1;
          end
          OP_MASS:   begin
            prot_q    <= '0;
            prot_done <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_rd    = cmd_q;
  assign status    = {st_cmd, st_acc, busy, st_fail, st_pass};
  assign read_word = read_q;
  assign signature = sig_q;
  assign prot_mask = prot_q;
  assign irq       = irq_q;
endmodule

// File: rtl/flc_chk.sv
module flc_chk #(
  parameter int ST_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            start,
  input logic [7:0]      cmd_rd,
  input logic [ST_W-1:0] status,
  input logic            irq,
  input logic            kernel_touch,
  input logic            mass_start,
  input logic            armed
);
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R2
  busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cmd_rd != 8'h07);

  // R2
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cmd_rd == 8'h07) && !busy);

  // R13
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);

  // R6
  verify_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]));

  // R11
  kernel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kernel_touch);

  // R8
  mass_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mass_start |-> armed);
endmodule

bind flash_cmd_ctrl flc_chk #(.ST_W(5)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .start(start),
  .cmd_rd(cmd_rd), .status(status), .irq(irq),
  .kernel_touch(kernel_touch), .mass_start(mass_start), .armed(armed)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int WORDS = 64, PW = 8, KP = 1, PAGES = WORDS / PW, USERW = (PAGES - KP) * PW;
  localparam int TR = 2, TW = 6, TEW = 20, TV = 3, TPE = 10, TM = 24, TS = 70, TP = 4;
  localparam logic [15:0] UNLOCK = 16'hC3A5, CLR = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:0]  cmd_rd;
  logic [4:0]  status;
  logic [15:0] read_word;
  logic [23:0] signature;
  logic [PAGES-1:0] prot_mask;
  logic        irq;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [15:0] m [WORDS];
  logic [PAGES-1:0] prot;
  bit prot_done;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.WORDS(WORDS), .PAGE_WORDS(PW), .KERNEL_PAGES(KP),
    .T_READ(TR), .T_WRITE(TW), .T_ERWR(TEW), .T_VERIFY(TV), .T_PERASE(TPE),
    .T_MASS(TM), .T_SIG(TS), .T_PROT(TP), .UNLOCK_KEY(UNLOCK), .CLEAR_KEY(CLR)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .cmd_rd(cmd_rd), .status(status), .read_word(read_word), .signature(signature),
    .prot_mask(prot_mask), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model_sig();
    logic [23:0] s = 24'hFFFFFF;
    for (int i = 0; i < WORDS; i++) begin
      logic fb = s[23];
      s = (s << 1) ^ {8'h00, m[i]};
      if (fb) s = s ^ 24'h80001B;
    end
    return s;
  endfunction

  function automatic bit guarded(input int a);
    int pg = a / PW;
    return (pg >= PAGES - KP) || prot[pg];
  endfunction

  task automatic bus(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // issue a command, measure the busy window and the completion interrupt
  task automatic run_cmd(input logic [7:0] code, input int len, input bit exp_irq,
                         input bit poke, input string tag);
    int n = 0;
    bus(2'd2, {8'h00, code});
    if (len == 0) begin
      chk(cmd_rd == 8'h07 && !status[2], {tag, " R2 immediate return"}, {cmd_rd, 3'b0, status[2]}, {8'h07, 4'h0});
      chk(irq == exp_irq, {tag, " R13 irq on immediate"}, irq, exp_irq);
    end else begin
      chk(cmd_rd == code, {tag, " R2 code while busy"}, cmd_rd, code);
      while (status[2] && n < 1000) begin
        n++;
        if (poke && n == 2) begin
          bus_wr = 1'b1; bus_sel = 2'd0; bus_wdata = 16'h003F;
        end else bus_wr = 1'b0;
        @(negedge clk);
      end
      bus_wr = 1'b0;
      chk(n == len, {tag, " R3 busy length"}, n, len);
      chk(cmd_rd == 8'h07, {tag, " R2 done value"}, cmd_rd, 8'h07);
      chk(irq == 1'b1, {tag, " R13 irq at completion"}, irq, 1);
    end
    @(negedge clk);
    chk(irq == 1'b0, {tag, " R13 irq one cycle"}, irq, 0);
  endtask

  task automatic do_read(input int a, input string tag);
    bus(2'd0, 16'(a));
    run_cmd(8'h01, TR, 1'b1, 1'b0, tag);
    chk(read_word == m[a], {tag, " R4 read word"}, read_word, m[a]);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < WORDS; a++) do_read(a, tag);
  endtask

  // one modifying op (2,3,5) with model update and refusal check
  task automatic do_mod(input logic [7:0] code, input int a, input logic [15:0] d, input string tag);
    int len;
    bit g = guarded(a);
    len = (code == 8'h02) ? TW : (code == 8'h03) ? TEW : TPE;
    bus(2'd0, 16'(a));
    bus(2'd1, d);
    run_cmd(code, g ? 0 : len, 1'b1, 1'b0, tag);
    chk(status[3] == g, {tag, " R11 access error"}, status[3], g);
    if (!g) begin
      if (code != 8'h02)
        for (int i = (a / PW) * PW; i < (a / PW) * PW + PW; i++) m[i] = 16'hFFFF;
      if (code != 8'h05) m[a] = d;
    end
  endtask

  task automatic do_verify(input int a, input logic [15:0] d, input string tag);
    bit eq = (m[a] == d);
    bus(2'd0, 16'(a));
    bus(2'd1, d);
    run_cmd(8'h04, TV, 1'b1, 1'b0, tag);
    chk(status[1:0] == {!eq, eq}, {tag, " R6 verify bits"}, status[1:0], {!eq, eq});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) m[i] = (i >= USERW) ? (16'hA000 | 16'(i)) : 16'hFFFF;
    prot = '0; prot_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_rd == 8'h07, "R1 cmd reset", cmd_rd, 8'h07);
    chk(status == 5'b0 && !irq && prot_mask == '0, "R1 status reset", {status, irq, prot_mask}, 0);
    chk(signature == 24'h0 && read_word == 16'h0, "R1 results reset", {signature, read_word}, 0);
    do_read(WORDS - 1, "R1 kernel word");
    do_read(0, "R1 user word");

    // R4 write then read; R3 address write during busy ignored
    do_mod(8'h02, 5, 16'h1234, "R4 write");
    bus(2'd0, 16'd5);
    run_cmd(8'h01, TR, 1'b1, 1'b1, "R3 poke");
    chk(read_word == 16'h1234, "R3 write while busy ignored", read_word, 16'h1234);

    // R6 verify both ways
    do_verify(5, 16'h1234, "R6 match");
    do_verify(5, 16'h1235, "R6 mismatch");

    // R5 erase-then-write, R7 page erase
    do_mod(8'h02, 12, 16'h0F0F, "R5 setup");
    do_mod(8'h03, 9, 16'hBEEF, "R5 erase-write");
    do_mod(8'h02, 20, 16'h7777, "R7 setup");
    do_mod(8'h05, 17, 16'h0, "R7 page erase");
    check_all("R5 R7 array");

    // R10 protect pages 2 and 5, then once-only
    bus(2'd1, 16'h0024);
    run_cmd(8'h0C, TP, 1'b1, 1'b0, "R10 protect");
    prot = 8'h24; prot_done = 1'b1;
    chk(prot_mask == 8'h24, "R10 mask", prot_mask, 8'h24);
    bus(2'd1, 16'h00FF);
    run_cmd(8'h0C, 0, 1'b1, 1'b0, "R10 second protect");
    chk(status[4] && prot_mask == 8'h24, "R10 second refused", {status[4], prot_mask}, {1'b1, 8'h24});

    // random mix, refusals on kernel and protected pages (R11)
    for (int k = 0; k < 60; k++) begin
      int r = $urandom % 4;
      int a = $urandom % WORDS;
      logic [15:0] d = 16'($urandom);
      if (k % 7 == 0) a = USERW + ($urandom % PW);
      case (r)
        0: do_mod(8'h02, a, d, "R11 rnd write");
        1: do_mod(8'h03, a, d, "R11 rnd erase-write");
        2: do_mod(8'h05, a, d, "R11 rnd page erase");
        default: do_verify(a, (k % 2 == 0) ? m[a] : d, "R6 rnd verify");
      endcase
    end
    check_all("R11 array after random");

    // R10 clear key re-enables protect
    bus(2'd3, CLR);
    @(negedge clk);
    chk(prot_mask == '0, "R10 clear key", prot_mask, 0);
    prot = '0; prot_done = 1'b0;
    bus(2'd1, 16'h0001);
    run_cmd(8'h0C, TP, 1'b1, 1'b0, "R10 protect again");
    prot = 8'h01;
    chk(status[4] == 1'b0 && prot_mask == 8'h01, "R10 protect after clear", {status[4], prot_mask}, 9'h001);
    do_mod(8'h05, 3, 16'h0, "R11 protected page erase");

    // R12 reserved codes, ping, null
    run_cmd(8'h07, 0, 1'b1, 1'b0, "R12 reserved 07");
    chk(status[4], "R12 reserved 07 error", status[4], 1);
    run_cmd(8'h1F, 0, 1'b1, 1'b0, "R12 reserved 1F");
    chk(status[4], "R12 reserved 1F error", status[4], 1);
    run_cmd(8'h0F, 0, 1'b1, 1'b0, "R12 ping");
    chk(status == 5'b0, "R12 ping clears status", status, 0);
    run_cmd(8'h00, 0, 1'b0, 1'b0, "R13 null no irq");

    // R8 mass erase guard
    run_cmd(8'h06, 0, 1'b1, 1'b0, "R8 no key");
    chk(status[4], "R8 no key error", status[4], 1);
    bus(2'd3, UNLOCK);
    run_cmd(8'h0F, 0, 1'b1, 1'b0, "R8 ping between");
    run_cmd(8'h06, 0, 1'b1, 1'b0, "R8 stale key");
    chk(status[4], "R8 stale key error", status[4], 1);
    check_all("R8 array untouched");
    bus(2'd3, UNLOCK);
    run_cmd(8'h06, TM, 1'b1, 1'b0, "R8 mass erase");
    for (int i = 0; i < USERW; i++) m[i] = 16'hFFFF;
    prot = '0; prot_done = 1'b0;
    chk(prot_mask == '0 && status[4] == 1'b0, "R8 protection cleared", {status[4], prot_mask}, 0);
    check_all("R8 kernel kept");

    // R9 signature after a few writes
    for (int k = 0; k < 6; k++) do_mod(8'h02, $urandom % USERW, 16'($urandom), "R9 fill");
    run_cmd(8'h0B, TS, 1'b1, 1'b0, "R9 signature");
    chk(signature == model_sig(), "R9 signature value", signature, model_sig());

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule